// File: doc/BRIEF.md
# Universal Iterative CORDIC Engine

This block is a sequential fixed-point CORDIC unit. The caller supplies a complete X, Y, Z triple together with a coordinate system and a direction rule. The unit then applies one micro-rotation per clock cycle until the sweep is complete, and returns the updated triple. The same datapath serves circular, linear and hyperbolic coordinates. It drives either Z toward zero (rotation) or Y toward zero (vectoring), and the choice is made per operation.

All values are 16-bit signed two's complement Q2.14 numbers: a sign bit, one integer bit and fourteen fraction bits. Elementary angles come from an internal constant table. Outputs are not gain-compensated. Inputs are not range-reduced, so the caller keeps operands inside the convergence region. A one-cycle `start` pulse begins an operation, and a one-cycle `done` pulse marks its end.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `x_out`, `y_out` and `z_out` are all 0.
- R2: A `start` sampled while `busy` is 0 loads `x_in`, `y_in`, `z_in`, `coord_sel` and `vec_mode`. At the next clock the outputs equal the loaded triple and `busy` is 1.
- R3: `done` rises exactly 14 clocks after the loading edge for circular and linear operations, and exactly 15 clocks after it for hyperbolic operations. `done` lasts one cycle, and `busy` is 0 whenever `done` is 1.
- R4: In rotation (`vec_mode`=0) the step sign d is +1 when Z ≥ 0 and −1 when Z < 0. Circular steps compute x' = x − d·(y>>>i), y' = y + d·(x>>>i) and z' = z − d·atan(2^−i), with the shift index i running from 0 to 13.
- R5: In vectoring (`vec_mode`=1) the step sign d is −1 when Y ≥ 0 and +1 when Y < 0, in every coordinate system.
- R6: Linear steps leave X unchanged and use the constant 2^−i (0x4000 >> i) for Z, with i running from 0 to 13.
- R7: Hyperbolic steps compute x' = x + d·(y>>>i) and use atanh(2^−i) for Z. The shift index runs 1,2,3,4,4,5,…,13,13, so i=4 and i=13 are each applied twice.
- R8: `coord_sel` encodes 00 as circular, 01 as linear and 10 as hyperbolic. The spare code 11 behaves exactly like circular.
- R9: A `start` that arrives while `busy` is 1 is ignored, and the running operation completes with its own operands.
- R10: After `done`, the outputs hold their values until the next accepted `start`, whatever the other inputs do.
- R11: Shifts are arithmetic, and every addition wraps modulo 2^16 without saturation.
- R12: Each table constant is atan(2^−i) or atanh(2^−i) scaled by 2^14 and rounded to the nearest integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while idle) |
| vec_mode | input | 1 | 0 = rotation, 1 = vectoring |
| coord_sel | input | 2 | 00 circular, 01 linear, 10 hyperbolic, 11 circular |
| x_in | input | 16 | Initial X, Q2.14 |
| y_in | input | 16 | Initial Y, Q2.14 |
| z_in | input | 16 | Initial Z, Q2.14 |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current or final X, Q2.14 |
| y_out | output | 16 | Current or final Y, Q2.14 |
| z_out | output | 16 | Current or final Z, Q2.14 |

## Verification
The loaded triple must appear one clock after the accepting edge. The final triple and the `done` pulse are due 14 clocks after that edge for circular and linear work and 15 clocks after it for hyperbolic work. Each queued expectation records its due cycle when the start pulse is driven. The monitor samples one nanosecond after each rising edge and compares both the triple and the actual cycle of `done` against that record. The hold and ignored-start checks sample the outputs at falling edges several cycles after the disturbing stimulus, before any new operation is accepted.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int DW     = 16;
  localparam int FW     = 14;
  localparam int NITER  = 14;
  localparam int IW     = $clog2(NITER);
  localparam int REP_LO = 4;

  typedef enum logic [1:0] {
    CS_CIRC  = 2'b00,
    CS_LIN   = 2'b01,
    CS_HYP   = 2'b10,
    CS_SPARE = 2'b11
  } coord_e;

  typedef logic signed [DW-1:0] word_t;

  typedef struct packed {
    word_t x;
    word_t y;
    word_t z;
  } triple_t;

  function automatic coord_e norm_coord(input logic [1:0] c);
    return (c == CS_SPARE) ? CS_CIRC : coord_e'(c);
  endfunction

  function automatic word_t add_sub(input word_t a, input word_t b, input logic sub);
    return sub ? word_t'(a - b) : word_t'(a + b);
  endfunction

  function automatic word_t atan_q(input logic [IW-1:0] i);
    case (i)
      4'd0:    return 16'sd12868;
      4'd1:    return 16'sd7596;
      4'd2:    return 16'sd4014;
      4'd3:    return 16'sd2037;
      4'd4:    return 16'sd1023;
      4'd5:    return 16'sd512;
      default: return word_t'(16'h4000 >> i);
    endcase
  endfunction

  function automatic word_t atanh_q(input logic [IW-1:0] i);
    case (i)
      4'd1:    return 16'sd9000;
      4'd2:    return 16'sd4185;
      4'd3:    return 16'sd2059;
      4'd4:    return 16'sd1025;
      4'd5:    return 16'sd512;
      4'd0:    return 16'sd0;
      default: return word_t'(16'h4000 >> i);
    endcase
  endfunction
endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom
  import cordic_pkg::*;
(
  input  coord_e          coord,
  input  logic [IW-1:0]   idx,
  output word_t           angle
);
  always_comb begin
    case (coord)
      CS_LIN:  angle = word_t'(16'h4000 >> idx);
      CS_HYP:  angle = atanh_q(idx);
      default: angle = atan_q(idx);
    endcase
  end
endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot
  import cordic_pkg::*;
(
  input  coord_e          coord,
  input  logic            vec,
  input  logic [IW-1:0]   idx,
  input  triple_t         cur,
  input  word_t           angle,
  output triple_t         nxt,
  output logic            dir_neg
);
  word_t xs, ys;

  always_comb begin
    xs      = cur.x >>> idx;
    ys      = cur.y >>> idx;
    dir_neg = vec ? ~cur.y[DW-1] : cur.z[DW-1];
    nxt.y   = add_sub(cur.y, xs, dir_neg);
    nxt.z   = add_sub(cur.z, angle, ~dir_neg);
    case (coord)
      CS_LIN:  nxt.x = cur.x;
      CS_HYP:  nxt.x = add_sub(cur.x, ys, dir_neg);
      default: nxt.x = add_sub(cur.x, ys, ~dir_neg);
    endcase
  end
endmodule

// File: rtl/cordic_seq.sv
module cordic_seq
  import cordic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  coord_e          coord_in,
  output logic            load,
  output logic            busy,
  output logic            done,
  output logic [IW-1:0]   idx,
  output coord_e          coord_act
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NITER - 1);
  localparam logic [IW-1:0] REP_IDX  = IW'(REP_LO);

  logic rep;
  logic last;
  logic want_rep;

  assign load     = start & ~busy;
  assign want_rep = (coord_act == CS_HYP) && !rep && (idx == REP_IDX || idx == LAST_IDX);
  assign last     = (idx == LAST_IDX) && ((coord_act != CS_HYP) || rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      rep       <= 1'b0;
      coord_act <= CS_CIRC;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy      <= 1'b1;
        coord_act <= coord_in;
        idx       <= (coord_in == CS_HYP) ? IW'(1) : '0;
        rep       <= 1'b0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (want_rep) begin
          rep <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          rep <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        vec_mode,
  input  logic [1:0]  coord_sel,
  input  logic [15:0] x_in,
  input  logic [15:0] y_in,
  input  logic [15:0] z_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] x_out,
  output logic [15:0] y_out,
  output logic [15:0] z_out
);
  coord_e          coord_in;
  coord_e          coord_act;
  logic            load;
  logic [IW-1:0]   shift_idx;
  word_t           angle;
  triple_t         state_q;
  triple_t         state_nxt;
  logic            vec_q;
  logic            dir_neg;

  assign coord_in = norm_coord(coord_sel);

  cordic_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .coord_in  (coord_in),
    .load      (load),
    .busy      (busy),
    .done      (done),
    .idx       (shift_idx),
    .coord_act (coord_act)
  );

  cordic_angle_rom u_rom (
    .coord (coord_act),
    .idx   (shift_idx),
    .angle (angle)
  );

  cordic_microrot u_step (
    .coord   (coord_act),
    .vec     (vec_q),
    .idx     (shift_idx),
    .cur     (state_q),
    .angle   (angle),
    .nxt     (state_nxt),
    .dir_neg (dir_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      vec_q   <= 1'b0;
    end else if (load) begin
      state_q <= '{x: word_t'(x_in), y: word_t'(y_in), z: word_t'(z_in)};
      vec_q   <= vec_mode;
    end else if (busy) begin
      state_q <= state_nxt;
    end
  end

  assign x_out = state_q.x;
  assign y_out = state_q.y;
  assign z_out = state_q.z;
endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  coord_sel,
  input logic [15:0] x_in,
  input logic [15:0] y_in,
  input logic [15:0] z_in,
  input logic        busy,
  input logic        done,
  input logic [15:0] x_out,
  input logic [15:0] y_out,
  input logic [15:0] z_out,
  input logic [3:0]  shift_idx,
  input logic [1:0]  coord_act
);
  AST_LOAD_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && x_out == $past(x_in) && y_out == $past(y_in) && z_out == $past(z_in))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out))); // R10

  AST_LIN_X_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && coord_act == 2'b01) |=> $stable(x_out)); // R6

  AST_HYP_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && coord_sel == 2'b10) |=> (shift_idx == 4'd1)); // R7

  AST_CIRC_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && coord_sel == 2'b11) |=> (shift_idx == 4'd0 && coord_act == 2'b00)); // R8

  AST_BUSY_KEEPS_IDX_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R9
endmodule

bind cordic_engine cordic_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .coord_sel (coord_sel),
  .x_in      (x_in),
  .y_in      (y_in),
  .z_in      (z_in),
  .busy      (busy),
  .done      (done),
  .x_out     (x_out),
  .y_out     (y_out),
  .z_out     (z_out),
  .shift_idx (shift_idx),
  .coord_act (coord_act)
);

// File: tb/tb_cordic_engine.sv
`timescale 1ns/1ps
module tb_cordic_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        vec_mode = 1'b0;
  logic [1:0]  coord_sel = 2'b00;
  logic [15:0] x_in = '0, y_in = '0, z_in = '0;
  logic        busy, done;
  logic [15:0] x_out, y_out, z_out;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  typedef struct {
    logic signed [15:0] x, y, z;
    int    due;
    string req;
  } exp_t;

  exp_t scb[$];
  logic signed [15:0] last_x, last_y, last_z;

  cordic_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_mode(vec_mode),
    .coord_sel(coord_sel), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .busy(busy), .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // R12: constants rounded from the exact functions
  function automatic int econst(input bit [1:0] cs, input int i);
    real t, a;
    t = 1.0 / (2.0 ** i);
    if (cs == 2'b01)      a = t;
    else if (cs == 2'b10) a = 0.5 * $ln((1.0 + t) / (1.0 - t));
    else                  a = $atan(t);
    return $rtoi(a * 16384.0 + 0.5);
  endfunction

  // Independent restatement of R4..R8, R11
  function automatic void model(input bit vec, input bit [1:0] cs,
                                inout logic signed [15:0] x, inout logic signed [15:0] y,
                                inout logic signed [15:0] z, output int lat);
    int sched[$];
    int m;
    m = (cs == 2'b01) ? 0 : (cs == 2'b10) ? -1 : 1;
    if (cs == 2'b10) begin
      for (int i = 1; i <= 13; i++) begin
        sched.push_back(i);
        if (i == 4 || i == 13) sched.push_back(i);
      end
    end else begin
      for (int i = 0; i <= 13; i++) sched.push_back(i);
    end
    lat = sched.size();
    foreach (sched[k]) begin
      int i, d, xs, ys, nx, ny, nz;
      i  = sched[k];
      d  = vec ? ((y < 0) ? 1 : -1) : ((z < 0) ? -1 : 1);
      xs = int'(x >>> i);
      ys = int'(y >>> i);
      nx = int'(x) - m * d * ys;
      ny = int'(y) + d * xs;
      nz = int'(z) - d * econst(cs, i);
      x  = 16'(nx);
      y  = 16'(ny);
      z  = 16'(nz);
    end
  endfunction

  task automatic run_op(input bit vec, input bit [1:0] cs, input int xi, input int yi,
                        input int zi, input string req, input bit disturb);
    exp_t e;
    int   lat;
    logic signed [15:0] mx, my, mz;
    mx = 16'(xi); my = 16'(yi); mz = 16'(zi);
    model(vec, cs, mx, my, mz, lat);
    @(negedge clk);
    vec_mode = vec; coord_sel = cs;
    x_in = 16'(xi); y_in = 16'(yi); z_in = 16'(zi);
    start = 1'b1;
    e.x = mx; e.y = my; e.z = mz; e.due = cyc + 1 + lat; e.req = req;
    scb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(x_out === 16'(xi) && y_out === 16'(yi) && z_out === 16'(zi), "R2", "loaded x",
        int'($signed(x_out)), xi);
    if (disturb) begin
      repeat (3) @(negedge clk);
      x_in = 16'sd5000; y_in = -16'sd3000; z_in = 16'sd1234;
      vec_mode = ~vec; coord_sel = 2'b10;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (scb.size() != 0) @(negedge clk);
    last_x = mx; last_y = my; last_z = mz;
  endtask

  // Monitor: pops expectations as done pulses appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done === 1'b1) begin
        if (scb.size() == 0) begin
          chk(1'b0, "R3", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = scb.pop_front();
          chk(cyc == e.due, "R3", {e.req, " done cycle"}, cyc, e.due);
          chk(busy === 1'b0, "R3", "busy at done", int'(busy), 0);
          chk($signed(x_out) == e.x, e.req, "x", int'($signed(x_out)), int'(e.x));
          chk($signed(y_out) == e.y, e.req, "y", int'($signed(y_out)), int'(e.y));
          chk($signed(z_out) == e.z, e.req, "z", int'($signed(z_out)), int'(e.z));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run hung", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(x_out === 16'd0 && y_out === 16'd0 && z_out === 16'd0, "R1", "outputs after reset",
        int'(x_out | y_out | z_out), 0);

    run_op(1'b0, 2'b00, 9949, 0, 8192, "R4", 1'b0);     // circular rotation, +z
    run_op(1'b0, 2'b00, 9949, 0, -8192, "R4", 1'b0);    // circular rotation, -z
    run_op(1'b1, 2'b00, 8000, 6000, 0, "R5", 1'b0);     // circular vectoring
    run_op(1'b1, 2'b00, 8000, -6000, 0, "R5", 1'b0);    // circular vectoring, y<0
    run_op(1'b0, 2'b01, 8192, 0, 8192, "R6", 1'b0);     // linear rotation
    run_op(1'b1, 2'b01, 12000, 6000, 0, "R6", 1'b0);    // linear vectoring
    run_op(1'b0, 2'b10, 16384, 0, 4096, "R7", 1'b0);    // hyperbolic rotation
    run_op(1'b1, 2'b10, 16000, 8000, 0, "R7", 1'b0);    // hyperbolic vectoring
    run_op(1'b0, 2'b11, 9949, 0, 8192, "R8", 1'b0);     // spare code as circular
    run_op(1'b0, 2'b01, 16384, 32000, 16384, "R11", 1'b0); // wrap without saturation
    run_op(1'b0, 2'b00, 9949, 0, 4000, "R9", 1'b1);     // start while busy ignored
    run_op(1'b1, 2'b10, 16000, -4000, 0, "R12", 1'b0);  // hyperbolic constants

    // R10: results hold while other inputs move and no start arrives
    x_in = 16'h1111; y_in = 16'h2222; z_in = 16'h3333;
    vec_mode = 1'b1; coord_sel = 2'b01;
    repeat (6) @(negedge clk);
    chk($signed(x_out) == last_x && $signed(y_out) == last_y && $signed(z_out) == last_z,
        "R10", "held x", int'($signed(x_out)), int'(last_x));
    chk(busy === 1'b0 && done === 1'b0, "R10", "idle flags", int'(busy) + int'(done), 0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule